// File: doc/BRIEF.md
# Subcarrier Tag Response Encoder

This block turns a response frame into the serial load-modulation stream that a contactless tag emulator drives onto its antenna switch. Firmware or an upstream engine supplies the frame length and an optional count of leading quiet groups, pulses a start request, and then feeds the response bytes over a valid/ready handshake. The encoder produces a fixed start-of-frame chip pattern, Manchester-codes each byte, appends a fixed end-of-frame pattern and two trailing quiet groups, and then reports completion.

The encoder works on chips and on groups of eight chips. A chip of value 1 is a burst of eight subcarrier pulses at one thirty-second of the carrier, and a chip of value 0 is an equally long unmodulated interval. The block is clocked at the system clock and advances only on cycles where the carrier-rate enable is high, so one chip spans 256 enabled cycles.

Top module: `subcarrier_resp_enc`

## Requirements
- R1: While and directly after reset, `busy`, `done`, `mod_out` and `in_ready` are all low.
- R2: A start request is taken only on an enabled cycle while `busy` is low; `busy` rises after that edge, and a start request (with any length or delay values) while `busy` is high changes nothing in the running frame.
- R3: Each chip lasts 256 enabled cycles. A chip of value 1 drives `mod_out` high for 16 enabled cycles and low for 16, eight times; a chip of value 0 keeps `mod_out` low. With `busy` low, `mod_out` is low.
- R4: A frame is, in sending order: `delay_grps` groups of eight 0-chips, the start chips 0,0,0,1,1,1,0,1, the data chips, the end chips 1,0,1,1,1,0,0,0, and sixteen 0-chips. `busy` stays high for exactly that many chips times 256 enabled cycles.
- R5: Each data bit becomes two chips: a 1 bit gives 0 then 1, a 0 bit gives 1 then 0. Bytes go out with bit 0 first and bit 7 last (low nibble, then high nibble, each least significant bit first).
- R6: With `frame_len` of 0 the frame holds start chips, end chips and the sixteen trailing 0-chips only, and `in_ready` never rises.
- R7: A `frame_len` above `MAX_BYTES` is treated as `MAX_BYTES`.
- R8: `in_ready` is high only while `busy`, on enabled cycles, while the one-byte holding slot is empty and fewer bytes than the frame length have been taken; it falls after each transfer, and exactly the frame length in bytes is pulled when the source keeps up.
- R9: If no byte has arrived by the time a byte's first chip group begins, that byte is sent as 0x00 and the frame keeps its length.
- R10: `done` is high for exactly one clock cycle, in the cycle right after `busy` falls at the end of the last trailing chip.
- R11: On cycles with `ce` low, the chip stream, the pulse phase and `busy` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted inside the block through a two-stage synchronizer |
| ce | input | 1 | Carrier-rate enable; the encoder advances one carrier cycle per enabled clock |
| start | input | 1 | Request to begin a frame |
| frame_len | input | $clog2(MAX_BYTES+1) | Number of data bytes in the frame, sampled at start |
| delay_grps | input | DLY_W | Number of leading quiet eight-chip groups, sampled at start |
| in_data | input | 8 | Response byte |
| in_valid | input | 1 | `in_data` holds a byte |
| in_ready | output | 1 | The encoder takes `in_data` at this edge if `in_valid` is high |
| mod_out | output | 1 | Load-modulation drive, subcarrier pulses during 1-chips |
| busy | output | 1 | A frame is being sent |
| done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The bound checker watches on every cycle that the line is silent when idle, that `in_ready` only appears inside a frame and drops after each transfer, that a start on an idle enabled cycle always raises `busy`, that `done` is a single cycle following the fall of `busy`, and that a disabled cycle freezes the output. The exact chip order, the start and end patterns, the bit-to-chip pairs, the byte ordering, the clamp of long frames and the zero fill on a starved source can only be shown by the bench scenarios, where a behavioural model predicts `mod_out`, `busy` and `done` for every clock, including a run with a gapped enable and a start request injected mid-frame.

// File: rtl/sre_pkg.sv
package sre_pkg;

  localparam int GRP_CHIPS = 8;

  localparam logic [GRP_CHIPS-1:0] SOF_CHIPS = 8'b0001_1101;
  localparam logic [GRP_CHIPS-1:0] EOF_CHIPS = 8'b1011_1000;

  typedef enum logic [2:0] {
    GK_DELAY = 3'd0,
    GK_SOF   = 3'd1,
    GK_LO    = 3'd2,
    GK_HI    = 3'd3,
    GK_EOF   = 3'd4,
    GK_TAIL  = 3'd5
  } grp_kind_e;

  // Chip group for one nibble: bit 0 leads, each bit is a pair (1 -> 01, 0 -> 10),
  // group is shifted out from its most significant chip.
  function automatic logic [GRP_CHIPS-1:0] nib_chips(input logic [3:0] nib);
    logic [GRP_CHIPS-1:0] g;
    for (int i = 0; i < 4; i++) begin
      g[GRP_CHIPS-1-2*i -: 2] = nib[i] ? 2'b01 : 2'b10;
    end
    return g;
  endfunction

endpackage

// File: rtl/sre_chip_timer.sv
module sre_chip_timer #(
  parameter int CHIP_CYC  = 256,
  parameter int GRP_CHIPS = 8,
  localparam int CYC_W    = $clog2(CHIP_CYC),
  localparam int IDX_W    = $clog2(GRP_CHIPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             restart,
  input  logic             run,
  output logic [CYC_W-1:0] cyc_o,
  output logic             chip_end,
  output logic             grp_end
);

  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  assign chip_end = run & ce & (cyc_q == CYC_W'(CHIP_CYC - 1));
  assign grp_end  = chip_end & (idx_q == IDX_W'(GRP_CHIPS - 1));
  assign cyc_o    = cyc_q;

  always_comb begin
    cyc_d = cyc_q;
    idx_d = idx_q;
    if (restart) begin
      cyc_d = '0;
      idx_d = '0;
    end else if (run && ce) begin
      if (chip_end) begin
        cyc_d = '0;
        idx_d = grp_end ? '0 : idx_q + IDX_W'(1);
      end else begin
        cyc_d = cyc_q + CYC_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      idx_q <= '0;
    end else begin
      cyc_q <= cyc_d;
      idx_q <= idx_d;
    end
  end

endmodule

// File: rtl/sre_subcarrier.sv
module sre_subcarrier #(
  parameter int SUBC_HALF = 16,
  parameter int CYC_W     = 8
) (
  input  logic             chip,
  input  logic             run,
  input  logic [CYC_W-1:0] cyc,
  output logic             mod_out
);

  localparam logic [CYC_W-1:0] PERIOD = CYC_W'(2 * SUBC_HALF);
  localparam logic [CYC_W-1:0] HALF   = CYC_W'(SUBC_HALF);

  logic [CYC_W-1:0] phase;

  generate
    if ((SUBC_HALF & (SUBC_HALF - 1)) == 0) begin : g_pow2
      assign phase = cyc & (PERIOD - CYC_W'(1));
    end else begin : g_mod
      assign phase = cyc % PERIOD;
    end
  endgenerate

  assign mod_out = run & chip & (phase < HALF);

endmodule

// File: rtl/sre_frame_seq.sv
module sre_frame_seq
  import sre_pkg::*;
#(
  parameter int MAX_BYTES = 32,
  parameter int LEN_W     = 6,
  parameter int DLY_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             start,
  input  logic [LEN_W-1:0] frame_len,
  input  logic [DLY_W-1:0] delay_grps,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             chip_end,
  input  logic             grp_end,
  output logic             restart,
  output logic             run,
  output logic             chip,
  output logic             done
);

  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_BYTES);

  logic                 busy_q, busy_d;
  grp_kind_e            kind_q, kind_d;
  logic [GRP_CHIPS-1:0] grp_q, grp_d;
  logic [DLY_W-1:0]     dly_q, dly_d;
  logic [LEN_W-1:0]     len_q, len_d;
  logic [LEN_W-1:0]     take_q, take_d;
  logic [7:0]           slot_q, slot_d;
  logic                 slot_full_q, slot_full_d;
  logic [3:0]           hi_q, hi_d;
  logic                 tail_q, tail_d;
  logic                 done_q, done_d;

  logic                 accept;
  logic                 xfer;
  logic                 more;
  logic [7:0]           pull_byte;

  assign accept    = ce & start & ~busy_q;
  assign more      = (take_q < len_q);
  assign in_ready  = ce & busy_q & ~slot_full_q & more & ~grp_end;
  assign xfer      = in_valid & in_ready;
  assign pull_byte = slot_full_q ? slot_q : 8'h00;

  assign restart = accept;
  assign run     = busy_q;
  assign chip    = grp_q[GRP_CHIPS-1];
  assign done    = done_q;

  always_comb begin
    busy_d      = busy_q;
    kind_d      = kind_q;
    grp_d       = grp_q;
    dly_d       = dly_q;
    len_d       = len_q;
    take_d      = take_q;
    slot_d      = slot_q;
    slot_full_d = slot_full_q;
    hi_d        = hi_q;
    tail_d      = tail_q;
    done_d      = 1'b0;

    if (accept) begin
      busy_d      = 1'b1;
      len_d       = (frame_len > LEN_MAX) ? LEN_MAX : frame_len;
      take_d      = '0;
      slot_full_d = 1'b0;
      tail_d      = 1'b0;
      if (delay_grps != '0) begin
        kind_d = GK_DELAY;
        grp_d  = '0;
        dly_d  = delay_grps - DLY_W'(1);
      end else begin
        kind_d = GK_SOF;
        grp_d  = SOF_CHIPS;
      end
    end else if (busy_q) begin
      if (xfer) begin
        slot_d      = in_data;
        slot_full_d = 1'b1;
      end
      if (grp_end) begin
        unique case (kind_q)
          GK_DELAY: begin
            if (dly_q != '0) begin
              dly_d = dly_q - DLY_W'(1);
              grp_d = '0;
            end else begin
              kind_d = GK_SOF;
              grp_d  = SOF_CHIPS;
            end
          end
          GK_SOF, GK_HI: begin
            if (more) begin
              kind_d      = GK_LO;
              grp_d       = nib_chips(pull_byte[3:0]);
              hi_d        = pull_byte[7:4];
              take_d      = take_q + LEN_W'(1);
              slot_full_d = 1'b0;
            end else begin
              kind_d = GK_EOF;
              grp_d  = EOF_CHIPS;
            end
          end
          GK_LO: begin
            kind_d = GK_HI;
            grp_d  = nib_chips(hi_q);
          end
          GK_EOF: begin
            kind_d = GK_TAIL;
            grp_d  = '0;
            tail_d = 1'b0;
          end
          default: begin
            if (!tail_q) begin
              tail_d = 1'b1;
              grp_d  = '0;
            end else begin
              busy_d = 1'b0;
              done_d = 1'b1;
            end
          end
        endcase
      end else if (chip_end) begin
        grp_d = {grp_q[GRP_CHIPS-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      kind_q      <= GK_DELAY;
      grp_q       <= '0;
      dly_q       <= '0;
      len_q       <= '0;
      take_q      <= '0;
      slot_q      <= '0;
      slot_full_q <= 1'b0;
      hi_q        <= '0;
      tail_q      <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      busy_q      <= busy_d;
      kind_q      <= kind_d;
      grp_q       <= grp_d;
      dly_q       <= dly_d;
      len_q       <= len_d;
      take_q      <= take_d;
      slot_q      <= slot_d;
      slot_full_q <= slot_full_d;
      hi_q        <= hi_d;
      tail_q      <= tail_d;
      done_q      <= done_d;
    end
  end

endmodule

// File: rtl/subcarrier_resp_enc.sv
module subcarrier_resp_enc #(
  parameter int  MAX_BYTES   = 32,
  parameter int  DLY_W       = 8,
  parameter int  SUBC_HALF   = 16,
  parameter int  SUBC_PULSES = 8,
  localparam int LEN_W       = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             start,
  input  logic [LEN_W-1:0] frame_len,
  input  logic [DLY_W-1:0] delay_grps,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             mod_out,
  output logic             busy,
  output logic             done
);

  localparam int CHIP_CYC = 2 * SUBC_HALF * SUBC_PULSES;
  localparam int CYC_W    = $clog2(CHIP_CYC);

  logic [1:0]       rst_pipe;
  logic             rst_n_s;
  logic             restart;
  logic             run;
  logic             chip;
  logic             chip_end;
  logic             grp_end;
  logic [CYC_W-1:0] cyc;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_n_s = rst_pipe[1];

  sre_chip_timer #(
    .CHIP_CYC  (CHIP_CYC),
    .GRP_CHIPS (sre_pkg::GRP_CHIPS)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .ce       (ce),
    .restart  (restart),
    .run      (run),
    .cyc_o    (cyc),
    .chip_end (chip_end),
    .grp_end  (grp_end)
  );

  sre_frame_seq #(
    .MAX_BYTES (MAX_BYTES),
    .LEN_W     (LEN_W),
    .DLY_W     (DLY_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .ce         (ce),
    .start      (start),
    .frame_len  (frame_len),
    .delay_grps (delay_grps),
    .in_data    (in_data),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .chip_end   (chip_end),
    .grp_end    (grp_end),
    .restart    (restart),
    .run        (run),
    .chip       (chip),
    .done       (done)
  );

  sre_subcarrier #(
    .SUBC_HALF (SUBC_HALF),
    .CYC_W     (CYC_W)
  ) u_subc (
    .chip    (chip),
    .run     (run),
    .cyc     (cyc),
    .mod_out (mod_out)
  );

  assign busy = run;

endmodule

// File: rtl/sre_checker.sv
module sre_checker (
  input logic clk,
  input logic rst_n,
  input logic ce,
  input logic start,
  input logic in_valid,
  input logic in_ready,
  input logic mod_out,
  input logic busy,
  input logic done
);

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mod_out);

  assert_ready_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy);

  assert_ready_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_start_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && start && !busy) |=> busy);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce && busy) |=> ($stable(mod_out) && busy));

endmodule

bind subcarrier_resp_enc sre_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n_s),
  .ce       (ce),
  .start    (start),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .mod_out  (mod_out),
  .busy     (busy),
  .done     (done)
);

// File: tb/subcarrier_resp_enc_tb.sv
module subcarrier_resp_enc_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MAXB       = 4;
  localparam int LW         = $clog2(MAXB + 1);
  localparam int CHIP       = 256;
  localparam int HALF       = 16;
  localparam int WATCHDOG   = 190000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce;
  logic          start;
  logic [LW-1:0] frame_len;
  logic [7:0]    delay_grps;
  logic [7:0]    in_data;
  logic          in_valid;
  logic          in_ready;
  logic          mod_out;
  logic          busy;
  logic          done;

  always #(CLK_PERIOD / 2) clk = ~clk;

  subcarrier_resp_enc #(.MAX_BYTES(MAXB)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce         (ce),
    .start      (start),
    .frame_len  (frame_len),
    .delay_grps (delay_grps),
    .in_data    (in_data),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .mod_out    (mod_out),
    .busy       (busy),
    .done       (done)
  );

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   exp_chips[$];
  int   exp_total = 0;
  logic [7:0] src_mem [8];
  int   src_n = 0;
  int   src_base = 0;
  int   xfer_cnt;
  int   en_busy;
  int   ready_hi = 0;
  int   ce_mode = 0;
  int   ce_cnt = 0;
  bit   mon_on = 0;
  logic m_run;
  logic m_done;
  int   m_pos;

  assign in_valid = (xfer_cnt - src_base) < src_n;
  assign in_data  = src_mem[(xfer_cnt - src_base) & 7];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // enable pattern: always on, or two of every three cycles
  always @(negedge clk) begin
    ce_cnt <= ce_cnt + 1;
    ce     <= (ce_mode == 0) || ((ce_cnt % 3) != 2);
  end

  // behavioural reference: position counter over an expected chip list
  always @(posedge clk) begin
    if (!rst_n) begin
      m_run    <= 1'b0;
      m_done   <= 1'b0;
      m_pos    <= 0;
      xfer_cnt <= 0;
      en_busy  <= 0;
    end else begin
      m_done <= 1'b0;
      if (in_valid && in_ready) xfer_cnt <= xfer_cnt + 1;
      if (busy && ce) en_busy <= en_busy + 1;
      if (!m_run) begin
        if (ce && start) begin
          m_run <= 1'b1;
          m_pos <= 0;
        end
      end else if (ce) begin
        if (m_pos == exp_total * CHIP - 1) begin
          m_run  <= 1'b0;
          m_done <= 1'b1;
        end else begin
          m_pos <= m_pos + 1;
        end
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (mon_on) begin
      bit exp_mod;
      exp_mod = 1'b0;
      if (m_run)
        exp_mod = exp_chips[m_pos / CHIP] && ((m_pos % (2 * HALF)) < HALF);
      chk(mod_out === exp_mod, "R3,R4,R5,R11 mod_out", int'(mod_out), int'(exp_mod));
      chk(busy === m_run, "R2,R10 busy", int'(busy), int'(m_run));
      chk(done === m_done, "R10 done", int'(done), int'(m_done));
      chk(!(in_ready && !busy), "R8 in_ready outside frame", int'(in_ready), 0);
      if (in_ready) ready_hi++;
    end
  end

  task automatic push_pattern(input logic [7:0] pat);
    for (int k = 7; k >= 0; k--) exp_chips.push_back(pat[k]);
  endtask

  task automatic run_frame(input int dly, input int len, input int offered, input bit poke);
    int take;
    int e0;
    int x0;
    logic [7:0] b;
    exp_chips.delete();
    for (int k = 0; k < dly * 8; k++) exp_chips.push_back(1'b0);
    push_pattern(8'h1D);
    take = (len > MAXB) ? MAXB : len;
    for (int i = 0; i < take; i++) begin
      b = (i < offered) ? src_mem[i] : 8'h00;
      for (int k = 0; k < 8; k++) begin
        exp_chips.push_back(!b[k]);
        exp_chips.push_back(b[k]);
      end
    end
    push_pattern(8'hB8);
    for (int k = 0; k < 16; k++) exp_chips.push_back(1'b0);
    exp_total = exp_chips.size();
    src_base  = xfer_cnt;
    src_n     = offered;
    ready_hi  = 0;
    x0        = xfer_cnt;
    frame_len  = LW'(len);
    delay_grps = 8'(dly);
    start      = 1'b1;
    do @(negedge clk); while (!busy);
    e0    = en_busy;
    start = 1'b0;
    if (poke) begin
      repeat (3000) @(negedge clk);
      frame_len  = LW'(1);
      delay_grps = 8'd0;
      start      = 1'b1;
      repeat (10) @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1, "R2 start while busy ignored", int'(busy), 1);
    end
    do @(negedge clk); while (!done);
    chk((en_busy - e0) == exp_total * CHIP, "R4 enabled cycles in frame",
        en_busy - e0, exp_total * CHIP);
    chk((xfer_cnt - x0) == ((offered < take) ? offered : take), "R8 bytes pulled",
        xfer_cnt - x0, (offered < take) ? offered : take);
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R10 idle after done", int'({busy, done}), 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    start      = 1'b0;
    frame_len  = '0;
    delay_grps = '0;
    for (int i = 0; i < 8; i++) src_mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(done === 1'b0, "R1 done after reset", int'(done), 0);
    chk(mod_out === 1'b0, "R1 mod_out after reset", int'(mod_out), 0);
    chk(in_ready === 1'b0, "R1 in_ready after reset", int'(in_ready), 0);
    mon_on = 1'b1;

    // R4, R5: one delay group, two bytes
    src_mem[0] = 8'hA5; src_mem[1] = 8'h3C;
    run_frame(1, 2, 2, 1'b0);

    // R6: empty frame
    run_frame(0, 0, 0, 1'b0);
    chk(ready_hi == 0, "R6 in_ready during empty frame", ready_hi, 0);

    // R7: length above the maximum is clamped
    src_mem[0] = 8'h11; src_mem[1] = 8'h22; src_mem[2] = 8'h80;
    src_mem[3] = 8'hFE; src_mem[4] = 8'h77; src_mem[5] = 8'h01;
    run_frame(0, 7, 6, 1'b0);
    chk(exp_total == 1 * 8 + MAXB * 16 + 8 + 16, "R7 clamped chip count", exp_total,
        1 * 8 + MAXB * 16 + 8 + 16);

    // R9: source starves after the first byte
    src_mem[0] = 8'h5A;
    run_frame(0, 3, 1, 1'b0);

    // R11, R2: gapped enable, two delay groups, start poked mid-frame
    ce_mode = 1;
    src_mem[0] = 8'h96;
    run_frame(2, 1, 1, 1'b1);
    ce_mode = 0;

    mon_on = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule